// File: doc/BRIEF.md
# Time-Multiplexed Ripple Bandpass Filter

This block isolates the twice-line-frequency ripple (100 Hz) in a stream of 12-bit signed voltage samples. It is a second-order recursive bandpass section. A single multiplier and a single accumulator are shared across all five product terms, and a small sequencer steps through them one per clock.

A new sample is offered with a one-cycle start strobe. The block captures the sample and clears the accumulator. It then works through the feed-forward and feedback terms in a fixed order, scales the sum and saturates it. It then shifts its history and raises a one-cycle done pulse with the filtered sample. A strobe that arrives while a computation is running is dropped. The result can feed a duty-cycle correction path that needs the ripple component alone.

Top module: `ripple_bpf`

## Requirements
- R1: While rst_ni is low, and after it is released, y_o is 0 and done_o is 0. All history terms are zero, so the first result after reset is the zero-history response to its input.
- R2: Each result obeys y[n] = floor((160*x[n] + 0*x[n-1] - 160*x[n-2] + 1696*y[n-1] - 703*y[n-2]) / 1024). Here x and y are two's-complement 12-bit values, and the division is an arithmetic right shift by 10.
- R3: A scaled value above 2047 gives 2047, and one below -2048 gives -2048. The clipped value is the one held as y[n-1] for later samples.
- R4: If start_i is high at a rising edge while the block is idle, done_o is high for exactly one cycle after the sixth following rising edge. y_o takes the new result at that same edge.
- R5: A start_i pulse while a computation is running has no effect. It adds no done pulse and does not change the result or the history. sample_i is read only at the accepting edge.
- R6: y_o holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Strobe: accept sample_i and begin a computation |
| sample_i | input | 12 | Signed input sample |
| y_o | output | 12 | Signed filtered sample |
| done_o | output | 1 | One-cycle pulse when y_o is updated |

## Verification
An impulse followed by zeros exposes each feed-forward tap and the decaying feedback tail on its own. Any wrong coefficient, sign or shift appears as a distinct deviation. A full-scale sign reversal drives the output past both rails, which separates correct clipping and feedback of the clipped value from wraparound. An alternating full-scale pattern and a slow triangle check the rejection near Nyquist and near DC. Strobes injected mid-computation, with sample_i changed, and a reset in mid-stream show that busy strobes and stale history have no effect on later results.

// File: rtl/ripple_bpf_pkg.sv
package ripple_bpf_pkg;
  localparam int N_TERMS = 5;
  localparam int STEP_W  = $clog2(N_TERMS);
  localparam int COEF_W  = 12;

  localparam int CF_A0 = 160;
  localparam int CF_A1 = 0;
  localparam int CF_A2 = -160;
  localparam int CF_B0 = 1024;
  localparam int CF_B1 = -1696;
  localparam int CF_B2 = 703;
  localparam int NORM_SH = $clog2(CF_B0);

  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_WB} bpf_state_e;

  // term order: x[n], x[n-1], x[n-2], y[n-1], y[n-2]; feedback enters negated
  function automatic int eff_coef(input int k);
    case (k)
      0:       return CF_A0;
      1:       return CF_A1;
      2:       return CF_A2;
      3:       return -CF_B1;
      4:       return -CF_B2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [COEF_W-1:0] coef_mag(input logic [STEP_W-1:0] k);
    int c;
    c = eff_coef(int'(k));
    return COEF_W'((c < 0) ? -c : c);
  endfunction

  function automatic logic coef_sub(input logic [STEP_W-1:0] k);
    return eff_coef(int'(k)) < 0;
  endfunction
endpackage

// File: rtl/bpf_seq.sv
module bpf_seq
  import ripple_bpf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              cap_o,
  output logic              mac_o,
  output logic              wb_o,
  output logic [STEP_W-1:0] step_o
);
  bpf_state_e        state_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_MAC;
          step_q  <= '0;
        end
        ST_MAC: begin
          if (step_q == STEP_W'(N_TERMS-1)) state_q <= ST_WB;
          else step_q <= step_q + STEP_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cap_o  = (state_q == ST_IDLE) && start_i;
  assign mac_o  = (state_q == ST_MAC);
  assign wb_o   = (state_q == ST_WB);
  assign step_o = step_q;

  AST_START_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MAC && step_q == '0) |-> $past(state_q) == ST_IDLE); // R5
  AST_STEP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MAC && step_q != '0) |->
      ($past(state_q) == ST_MAC && step_q == $past(step_q) + STEP_W'(1))); // R4
endmodule

// File: rtl/bpf_hist.sv
module bpf_hist
  import ripple_bpf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 28
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cap_i,
  input  logic                            wb_i,
  input  logic signed [DATA_W-1:0]        sample_i,
  input  logic signed [ACC_W-1:0]         acc_i,
  output logic [N_TERMS-1:0][DATA_W-1:0]  data_o,
  output logic signed [DATA_W-1:0]        y_o
);
  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((1 << (DATA_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_MIN = ~Y_MAX;

  logic signed [DATA_W-1:0] x0_q, x1_q, x2_q, y1_q, y2_q, y_sat;
  logic signed [ACC_W-1:0]  acc_sh;

  always_comb begin
    acc_sh = acc_i >>> NORM_SH;
    if (acc_sh > Y_MAX)      y_sat = Y_MAX[DATA_W-1:0];
    else if (acc_sh < Y_MIN) y_sat = Y_MIN[DATA_W-1:0];
    else                     y_sat = acc_sh[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x0_q <= '0; x1_q <= '0; x2_q <= '0; y1_q <= '0; y2_q <= '0;
    end else begin
      if (cap_i) x0_q <= sample_i;
      if (wb_i) begin
        x1_q <= x0_q;
        x2_q <= x1_q;
        y1_q <= y_sat;
        y2_q <= y1_q;
      end
    end
  end

  assign data_o = {y2_q, y1_q, x2_q, x1_q, x0_q};
  assign y_o    = y1_q;

  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_i |=> (x1_q == $past(x0_q) && x2_q == $past(x1_q) && y2_q == $past(y1_q))); // R2
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_i |=> $stable(y1_q)); // R6
endmodule

// File: rtl/bpf_mac.sv
module bpf_mac
  import ripple_bpf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 28
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           en_i,
  input  logic [STEP_W-1:0]              step_i,
  input  logic [N_TERMS-1:0][DATA_W-1:0] data_i,
  output logic signed [ACC_W-1:0]        acc_o
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam logic signed [ACC_W-1:0] ACC_LIM = ACC_W'(1) <<< (ACC_W-2);

  logic [DATA_W-1:0]        data_sel;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, acc_q, acc_d;

  // data operand mux
  always_comb begin
    data_sel = '0;
    for (int k = 0; k < N_TERMS; k++)
      if (step_i == STEP_W'(k)) data_sel = data_i[k];
  end

  // shared multiplier: signed data times coefficient magnitude
  assign prod     = $signed(data_sel) * $signed({1'b0, coef_mag(step_i)});
  assign prod_ext = ACC_W'(prod);
  // shared adder
  assign acc_d    = coef_sub(step_i) ? acc_q - prod_ext : acc_q + prod_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  AST_ACC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q < ACC_LIM) && (acc_q > -ACC_LIM)); // R2
endmodule

// File: rtl/ripple_bpf.sv
module ripple_bpf
  import ripple_bpf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 28
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic                     done_o
);
  logic                           cap, mac, wb, done_q;
  logic [STEP_W-1:0]              step;
  logic [N_TERMS-1:0][DATA_W-1:0] data_vec;
  logic signed [ACC_W-1:0]        acc;

  bpf_seq u_seq (
    .clk_i, .rst_ni, .start_i,
    .cap_o (cap), .mac_o (mac), .wb_o (wb), .step_o (step)
  );

  bpf_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk_i, .rst_ni, .clr_i (cap), .en_i (mac), .step_i (step),
    .data_i (data_vec), .acc_o (acc)
  );

  bpf_hist #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_hist (
    .clk_i, .rst_ni, .cap_i (cap), .wb_i (wb), .sample_i,
    .acc_i (acc), .data_o (data_vec), .y_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= wb;
  end
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wb)); // R4
  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(y_o)); // R6
endmodule

// File: tb/sim_ripple_bpf.sv
`timescale 1ns/1ps
module sim_ripple_bpf;
  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic signed [11:0] sample_i = '0;
  logic signed [11:0] y_o;
  logic done_o;
  int n_run = 0, n_fail = 0, sat_hi = 0, sat_lo = 0;
  int mx1, mx2, my1, my2;

  always #4 clk = ~clk;

  ripple_bpf u0 (.clk_i(clk), .rst_ni, .start_i, .sample_i, .y_o, .done_o);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
  endfunction

  function automatic int model(input int x);
    int acc, y;
    acc = 160*x - 160*mx2 + 1696*my1 - 703*my2;
    y = acc >>> 10;
    if (y > 2047) y = 2047;
    if (y < -2048) y = -2048;
    mx2 = mx1; mx1 = x; my2 = my1; my1 = y;
    return y;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    start_i = 1'b0;
    model_clear();
    @(negedge clk);
    chk(y_o == 0, "R1 y_o in reset", int'(y_o), 0);
    chk(done_o == 0, "R1 done_o in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(y_o == 0 && done_o == 0, "R1 after release", int'(y_o), 0);
  endtask

  // glitch: strobe again mid-computation with a different sample
  task automatic run_sample(input int x, input bit glitch);
    int exp, prev;
    prev = my1;
    @(negedge clk);
    start_i = 1'b1;
    sample_i = 12'(x);
    exp = model(x);
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      if (i == 1) begin start_i = 1'b0; sample_i = 12'(x ^ 12'h5a5); end
      if (glitch && i == 3) begin start_i = 1'b1; sample_i = 12'(-x - 1); end
      if (glitch && i == 4) start_i = 1'b0;
      if (i < 7) begin
        chk(done_o == 0, glitch ? "R5 no early done" : "R4 no early done", int'(done_o), 0);
        chk(int'(y_o) == prev, "R6 y_o held while busy", int'(y_o), prev);
      end else begin
        chk(done_o == 1, "R4 done on sixth edge", int'(done_o), 1);
        chk(int'(y_o) == exp, glitch ? "R5 result with busy strobe" : "R2 result", int'(y_o), exp);
      end
    end
    if (exp == 2047) sat_hi++;
    if (exp == -2048) sat_lo++;
    @(negedge clk);
    chk(done_o == 0, "R4 single-cycle done", int'(done_o), 0);
    chk(int'(y_o) == exp, "R6 y_o held after done", int'(y_o), exp);
    if (glitch) begin
      @(negedge clk);
      chk(done_o == 0, "R5 no extra done", int'(done_o), 0);
    end
  endtask

  initial begin
    model_clear();
    do_reset();
    // impulse response
    run_sample(1000, 0);
    for (int i = 0; i < 12; i++) run_sample(0, 0);
    // full-scale reversal: clipping at both rails
    for (int i = 0; i < 40; i++) run_sample(-2048, 0);
    for (int i = 0; i < 15; i++) run_sample(2047, 0);
    for (int i = 0; i < 15; i++) run_sample(-2048, 0);
    chk(sat_hi > 0, "R3 upper clip reached", sat_hi, 1);
    chk(sat_lo > 0, "R3 lower clip reached", sat_lo, 1);
    // near-Nyquist alternating
    for (int i = 0; i < 20; i++) run_sample((i % 2) ? 1500 : -1500, 0);
    // slow triangle
    for (int i = 0; i < 60; i++) run_sample(((i % 40) < 20) ? (i % 40) * 90 - 900 : 2700 - (i % 40) * 90, 0);
    // busy strobes ignored
    for (int i = 0; i < 6; i++) run_sample(300 * i - 700, 1);
    // reset mid-stream clears history
    do_reset();
    run_sample(-1234, 0);
    run_sample(0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule